// File: doc/BRIEF.md
# Memory Readout Streaming Engine

The engine moves a stored image out of memory toward a FIFO that a host empties. It sits on the system clock and stays idle until a single-cycle start request arrives. It then captures a byte start address and a byte count, clears the downstream FIFO, and issues fixed-size burst read commands to a memory read port. Each returned 64-bit word is written into the FIFO one cycle after it arrives. Data moves only from memory toward the host.

Flow control depends on free space. The FIFO reports its fill level. The engine keeps a count of words it has asked for but has not yet written, and it issues a command only when the free space covers one more burst on top of those words. The FIFO therefore cannot overrun, whatever the memory latency or the host's drain rate. When the whole count has been requested and the last word has been written, the engine pulses a done signal and goes back to idle. A readout is a one-shot command: a start that arrives during a readout has no effect.

Top module: `rdo_stream_engine`

## Requirements
- R1: After reset and whenever idle, `busy_o`, `done_o`, `cmd_valid_o`, `fifo_wr_en_o` and `fifo_rst_o` are all low.
- R2: A `start_i` seen in idle captures `start_addr_i` and `byte_count_i`. From the next cycle `busy_o` is high, and `fifo_rst_o` is high for exactly CLR_CYCLES consecutive cycles. No command is issued while it is high.
- R3: A command is presented only when (FIFO_DEPTH − `fifo_level_i`) ≥ BURST_WORDS + words requested and not yet written. The FIFO never receives a write while it is full.
- R4: The first command address equals the captured start address. Each accepted command advances it by BURST_WORDS×8 bytes, modulo 2^ADDR_W.
- R5: A readout issues exactly ceil(count / (BURST_WORDS×8)) commands. A count of zero issues none.
- R6: Every word on `rd_data_i` with `rd_valid_i` high during a readout appears on `fifo_wr_data_o` with `fifo_wr_en_o` high one cycle later, in the same order. The total is BURST_WORDS words per command.
- R7: After the last word is written, `done_o` is high for exactly one cycle, and in that cycle `busy_o` is already low.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The address sequence, the command count and the data of the running readout do not change, and no new readout follows.
- R9: A command that is presented but not accepted stays presented with an unchanged address until `cmd_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Readout start request, one cycle |
| start_addr_i | input | ADDR_W (30) | Byte start address of the image |
| byte_count_i | input | CNT_W (24) | Number of bytes to read |
| cmd_valid_o | output | 1 | Burst read command presented |
| cmd_ready_i | input | 1 | Memory port accepts the command |
| cmd_addr_o | output | ADDR_W (30) | Byte address of the burst |
| rd_valid_i | input | 1 | Returned read word valid |
| rd_data_i | input | DATA_W (64) | Returned read word |
| fifo_wr_en_o | output | 1 | FIFO write strobe |
| fifo_wr_data_o | output | DATA_W (64) | FIFO write data |
| fifo_level_i | input | LVL_W (5) | Current FIFO fill level in words |
| fifo_rst_o | output | 1 | FIFO clear, held for CLR_CYCLES cycles |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | Readout complete, one cycle |

## Verification
The in-flight word count can grow and shrink in the same cycle: a command can be accepted while an earlier burst's word is being written to the FIFO. If the two updates conflict, flow control is lost. The sweeps provoke this with memory return latencies of one and four cycles and with a command port that accepts on every other cycle, so acceptances fall on the same edges as writes. The result is judged at the FIFO model: an overflow, a lost or reordered word, or a wrong command count shows up as a mismatch against the sequence computed from the start address. A second overlap is a start request injected in the middle of a readout. Its effect is judged by the command addresses and the word count being those of the first request only.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int unsigned RDO_ADDR_W = 30;
    localparam int unsigned RDO_CNT_W  = 24;
    localparam int unsigned RDO_DATA_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2
    } rdo_state_e;

    function automatic int unsigned burst_bytes(int unsigned words, int unsigned data_w);
        return words * (data_w / 8);
    endfunction

    function automatic int unsigned level_width(int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
    import rdo_pkg::*;
#(
    parameter int unsigned ADDR_W      = RDO_ADDR_W,
    parameter int unsigned CNT_W       = RDO_CNT_W,
    parameter int unsigned BURST_BYTES = 32,
    parameter int unsigned CLR_CYCLES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic              cmd_ready_i,
    input  logic              room_ok_i,
    input  logic              drained_i,
    output logic              cmd_valid_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              cmd_fire_o,
    output logic              fifo_rst_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int unsigned CLR_W = $clog2(CLR_CYCLES + 1);
    localparam logic [CNT_W-1:0]  STEP_CNT  = CNT_W'(BURST_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(BURST_BYTES);
    localparam logic [CLR_W-1:0]  CLR_LAST  = CLR_W'(CLR_CYCLES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
    } job_t;

    rdo_state_e       state_q;
    job_t             job_q;
    logic [CLR_W-1:0] clr_q;
    logic             done_q;
    logic             want_cmd;

    always_comb begin
        want_cmd    = (state_q == ST_RUN) && (job_q.left != '0);
        cmd_valid_o = want_cmd && room_ok_i;
        cmd_fire_o  = cmd_valid_o && cmd_ready_i;
        cmd_addr_o  = job_q.addr;
        fifo_rst_o  = (state_q == ST_CLEAR);
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            clr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        job_q.addr <= start_addr_i;
                        job_q.left <= byte_count_i;
                        clr_q      <= '0;
                        state_q    <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    clr_q <= clr_q + 1'b1;
                    if (clr_q == CLR_LAST) begin
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cmd_fire_o) begin
                        job_q.addr <= job_q.addr + STEP_ADDR;
                        job_q.left <= (job_q.left > STEP_CNT) ? (job_q.left - STEP_CNT) : '0;
                    end else if ((job_q.left == '0) && drained_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rdo_credit.sv
module rdo_credit
    import rdo_pkg::*;
#(
    parameter int unsigned BURST_WORDS = 4,
    parameter int unsigned FIFO_DEPTH  = 16,
    parameter int unsigned LVL_W       = level_width(16)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_fire_i,
    input  logic             wr_i,
    input  logic [LVL_W-1:0] fifo_level_i,
    output logic             room_ok_o,
    output logic             drained_o
);

    localparam int unsigned CR_W = LVL_W + 2;
    localparam logic [CR_W-1:0] BURST_CR = CR_W'(BURST_WORDS);
    localparam logic [CR_W-1:0] DEPTH_CR = CR_W'(FIFO_DEPTH);

    logic [CR_W-1:0] inflight_q;
    logic [CR_W-1:0] level_cr;
    logic [CR_W-1:0] free_cr;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= '0;
        end else begin
            unique case ({cmd_fire_i, wr_i})
                2'b10:   inflight_q <= inflight_q + BURST_CR;
                2'b01:   inflight_q <= inflight_q - 1'b1;
                2'b11:   inflight_q <= inflight_q + BURST_CR - 1'b1;
                default: inflight_q <= inflight_q;
            endcase
        end
    end

    always_comb begin
        level_cr  = CR_W'(fifo_level_i);
        free_cr   = (level_cr >= DEPTH_CR) ? '0 : (DEPTH_CR - level_cr);
        room_ok_o = free_cr >= (BURST_CR + inflight_q);
        drained_o = (inflight_q == '0);
    end

endmodule

// File: rtl/rdo_wpath.sv
module rdo_wpath
    import rdo_pkg::*;
#(
    parameter int unsigned DATA_W = RDO_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= rd_valid_i && accept_i;
            if (rd_valid_i && accept_i) begin
                wr_data_o <= rd_data_i;
            end
        end
    end

endmodule

// File: rtl/rdo_stream_engine.sv
module rdo_stream_engine
    import rdo_pkg::*;
#(
    parameter int unsigned ADDR_W      = RDO_ADDR_W,
    parameter int unsigned CNT_W       = RDO_CNT_W,
    parameter int unsigned DATA_W      = RDO_DATA_W,
    parameter int unsigned BURST_WORDS = 4,
    parameter int unsigned FIFO_DEPTH  = 16,
    parameter int unsigned CLR_CYCLES  = 2,
    parameter int unsigned LVL_W       = level_width(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [ADDR_W-1:0] cmd_addr_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              fifo_wr_en_o,
    output logic [DATA_W-1:0] fifo_wr_data_o,
    input  logic [LVL_W-1:0]  fifo_level_i,
    output logic              fifo_rst_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int unsigned BURST_BYTES = burst_bytes(BURST_WORDS, DATA_W);

    logic cmd_fire;
    logic room_ok;
    logic drained;

    rdo_ctrl #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .BURST_BYTES (BURST_BYTES),
        .CLR_CYCLES  (CLR_CYCLES)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .byte_count_i (byte_count_i),
        .cmd_ready_i  (cmd_ready_i),
        .room_ok_i    (room_ok),
        .drained_i    (drained),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_addr_o   (cmd_addr_o),
        .cmd_fire_o   (cmd_fire),
        .fifo_rst_o   (fifo_rst_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    rdo_credit #(
        .BURST_WORDS (BURST_WORDS),
        .FIFO_DEPTH  (FIFO_DEPTH),
        .LVL_W       (LVL_W)
    ) credit_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_fire_i   (cmd_fire),
        .wr_i         (fifo_wr_en_o),
        .fifo_level_i (fifo_level_i),
        .room_ok_o    (room_ok),
        .drained_o    (drained)
    );

    rdo_wpath #(
        .DATA_W (DATA_W)
    ) wpath_i (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (busy_o),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .wr_en_o    (fifo_wr_en_o),
        .wr_data_o  (fifo_wr_data_o)
    );

endmodule

// File: rtl/rdo_stream_engine_chk.sv
module rdo_stream_engine_chk #(
    parameter int unsigned ADDR_W      = 30,
    parameter int unsigned BURST_WORDS = 4,
    parameter int unsigned FIFO_DEPTH  = 16,
    parameter int unsigned LVL_W       = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid_o,
    input logic              cmd_ready_i,
    input logic [ADDR_W-1:0] cmd_addr_o,
    input logic              fifo_wr_en_o,
    input logic [LVL_W-1:0]  fifo_level_i,
    input logic              fifo_rst_o,
    input logic              busy_o,
    input logic              done_o
);

    // Independent count of words requested and not yet written, from ports only.
    int chk_infl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_infl <= 0;
        end else begin
            chk_infl <= chk_infl
                      + ((cmd_valid_o && cmd_ready_i) ? int'(BURST_WORDS) : 0)
                      - (fifo_wr_en_o ? 1 : 0);
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!cmd_valid_o && !fifo_rst_o));

    a_r2_clear_no_cmd: assert property (@(posedge clk) disable iff (rst)
        fifo_rst_o |-> (busy_o && !cmd_valid_o));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> ((int'(FIFO_DEPTH) - int'(fifo_level_i)) >= (int'(BURST_WORDS) + chk_infl)));

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_addr_o)));

endmodule

bind rdo_stream_engine rdo_stream_engine_chk #(
    .ADDR_W      (ADDR_W),
    .BURST_WORDS (BURST_WORDS),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .LVL_W       (LVL_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_addr_o   (cmd_addr_o),
    .fifo_wr_en_o (fifo_wr_en_o),
    .fifo_level_i (fifo_level_i),
    .fifo_rst_o   (fifo_rst_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/rdo_stream_engine_tb_top.sv
module rdo_stream_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BW    = 2;
    localparam int DEPTH = 8;
    localparam int CLR   = 2;
    localparam int BB    = BW * 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [29:0] start_addr_i = '0;
    logic [23:0] byte_count_i = '0;
    logic        cmd_valid_o;
    logic        cmd_ready = 1'b0;
    logic [29:0] cmd_addr_o;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic        fifo_wr_en_o;
    logic [63:0] fifo_wr_data_o;
    logic [LW-1:0] fifo_level = '0;
    logic        fifo_rst_o;
    logic        busy_o;
    logic        done_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdo_stream_engine #(
        .BURST_WORDS (BW),
        .FIFO_DEPTH  (DEPTH),
        .CLR_CYCLES  (CLR)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .start_addr_i   (start_addr_i),
        .byte_count_i   (byte_count_i),
        .cmd_valid_o    (cmd_valid_o),
        .cmd_ready_i    (cmd_ready),
        .cmd_addr_o     (cmd_addr_o),
        .rd_valid_i     (rd_valid),
        .rd_data_i      (rd_data),
        .fifo_wr_en_o   (fifo_wr_en_o),
        .fifo_wr_data_o (fifo_wr_data_o),
        .fifo_level_i   (fifo_level),
        .fifo_rst_o     (fifo_rst_o),
        .busy_o         (busy_o),
        .done_o         (done_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int lat = 1;
    int rdy_mode = 0;
    int drain_mode = 0;
    logic [29:0] exp_addr = '0;
    logic [26:0] exp_word = '0;
    int ncmd, nwords, bad_addr, bad_data, overflow, rst_cycles, done_cnt, hold_bad;

    logic [26:0] q_word [0:255];
    int          q_due  [0:255];
    int qh = 0;
    int qt = 0;
    int level = 0;
    bit          pend = 1'b0;
    logic [29:0] pend_addr = '0;

    function automatic logic [63:0] pat(logic [26:0] w);
        return {5'b0, w ^ 27'h5A3C3C5, 5'b0, w};
    endfunction

    task automatic chk(bit ok, string req, int act, int expv, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Memory port and FIFO models, updated at the active edge with nonblocking outputs.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (!rst) begin
                if (pend && (!cmd_valid_o || cmd_addr_o != pend_addr)) hold_bad++;   // R9
                pend = cmd_valid_o && !cmd_ready;
                pend_addr = cmd_addr_o;
                if (cmd_valid_o && cmd_ready) begin
                    if (cmd_addr_o !== exp_addr) bad_addr++;                       // R4
                    exp_addr = exp_addr + 30'(BB);
                    ncmd++;
                    for (int k = 0; k < BW; k++) begin
                        q_word[qt] = cmd_addr_o[29:3] + 27'(k);
                        q_due[qt]  = cyc + lat;
                        qt = (qt + 1) % 256;
                    end
                end
                if (qh != qt && q_due[qh] <= cyc) begin
                    rd_valid <= 1'b1;
                    rd_data  <= pat(q_word[qh]);
                    qh = (qh + 1) % 256;
                end else begin
                    rd_valid <= 1'b0;
                end
                if (fifo_rst_o) begin
                    level = 0;
                    rst_cycles++;
                end else begin
                    if (fifo_wr_en_o) begin
                        if (level >= DEPTH) overflow++;                                // R3
                        if (fifo_wr_data_o !== pat(exp_word)) bad_data++;               // R6
                        exp_word = exp_word + 27'd1;
                        nwords++;
                        level++;
                    end
                    if (level > 0 && (drain_mode == 0 || (cyc % 3) == 0)) level--;
                end
                fifo_level <= LW'(level);
                if (done_o) done_cnt++;
                cmd_ready <= (rdy_mode == 0) ? 1'b1 : ((cyc % 2) == 0);
            end
        end
    end

    task automatic run_case(logic [29:0] addr, int count, int rdy, int drain, int l, bit inject);
        int exp_cmds;
        bit got_done;
        exp_cmds = (count + BB - 1) / BB;
        @(negedge clk);
        rdy_mode = rdy; drain_mode = drain; lat = l;
        exp_addr = addr; exp_word = addr[29:3];
        ncmd = 0; nwords = 0; bad_addr = 0; bad_data = 0; overflow = 0;
        rst_cycles = 0; done_cnt = 0; hold_bad = 0;
        start_i = 1'b1; start_addr_i = addr; byte_count_i = 24'(count);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && fifo_rst_o, "R2", {30'b0, busy_o, fifo_rst_o}, 3, "busy and fifo clear after start");
        got_done = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (inject && i == 4) begin
                start_i = 1'b1; start_addr_i = 30'h0000_0800; byte_count_i = 24'd400;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin
                got_done = 1'b1;
                chk(!busy_o, "R7", int'(busy_o), 0, "busy low with done");
                break;
            end
        end
        start_i = 1'b0;
        chk(got_done, "R7", int'(got_done), 1, "done reached");
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R7", done_cnt, 1, "done pulse count");
        chk(ncmd == exp_cmds, "R5", ncmd, exp_cmds, "command count");
        chk(nwords == exp_cmds * BW, "R6", nwords, exp_cmds * BW, "words written");
        chk(bad_addr == 0, "R4", bad_addr, 0, "command address errors");
        chk(bad_data == 0, "R6", bad_data, 0, "data order errors");
        chk(overflow == 0, "R3", overflow, 0, "FIFO overflows");
        chk(rst_cycles == CLR, "R2", rst_cycles, CLR, "FIFO clear cycles");
        chk(hold_bad == 0, "R9", hold_bad, 0, "command hold violations");
        if (inject) begin
            chk(!busy_o && !cmd_valid_o, "R8", int'(busy_o), 0, "no readout after ignored start");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int counts [6] = '{0, 1, 16, 17, 40, 100};
        repeat (3) @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(!busy_o && !done_o && !cmd_valid_o && !fifo_wr_en_o && !fifo_rst_o, "R1",
            {27'b0, busy_o, done_o, cmd_valid_o, fifo_wr_en_o, fifo_rst_o}, 0, "outputs after reset");
        for (int c = 0; c < 6; c++) begin
            for (int r = 0; r < 2; r++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int li = 0; li < 2; li++) begin
                        run_case(((c + r) % 2 == 0) ? 30'h0000_0100 : 30'h3FFF_FFE0,
                                 counts[c], r, d, (li == 0) ? 1 : 4, counts[c] >= 40);
                    end
                end
            end
        end
        @(negedge clk);
        // R1: idle again after all runs
        chk(!busy_o && !cmd_valid_o && !fifo_wr_en_o, "R1",
            {29'b0, busy_o, cmd_valid_o, fifo_wr_en_o}, 0, "idle at end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule